// File: doc/BRIEF.md
# Gated Timer/Counter with Mode Select

This block is a 16-bit up-counter held in two byte-wide halves (a low byte and a high byte). A configuration byte picks the count source, an optional external gate and the counting layout. When the source is internal, the count advances on every clock cycle. When the source is external, the count advances once per high-to-low transition of a pin. The block samples that pin synchronously, so the fastest external rate is half the clock.

Two layouts are offered. In the 13-bit layout the five least significant bits of the low byte form a divide-by-32 prescaler, and each wrap of the prescaler carries into the high byte. In the 16-bit layout both bytes are cascaded directly. Software can load either byte at any time. A rollover of the full count sets a sticky overflow flag, which stays set until software clears it. The block is meant to sit beside a processor core as a general-purpose interval timer or event counter.

Top module: `gtc_timer`

## Requirements
- R1: After reset the count bytes, the stored configuration and the overflow flag are all zero.
- R2: A byte write (`lo_we` or `hi_we`) loads `wr_data` into that byte on the next edge. In any cycle that carries a byte write, neither byte increments. Both bytes read back on `lo_q`/`hi_q`.
- R3: With the internal source selected (configuration bit 6 = 0), the gate disabled and `run_en` high, the count advances by exactly one per clock cycle.
- R4: While `run_en` is low, the count holds its value.
- R5: With the gate enabled (configuration bit 7 = 1), counting happens only while `run_en` is high and `ext_gate` is high. `ext_gate` passes through a two-flop synchronizer, so it takes effect two clock cycles late.
- R6: With the external source selected (configuration bit 6 = 1), the count advances once for each 1-to-0 transition of the synchronized `ext_cnt`. Steady levels and rising edges do not count. Pulses as short as one clock cycle high and one clock cycle low are all counted.
- R7: Mode bits 00 (configuration bits 5:4) select the 13-bit layout. `lo_q[4:0]` is a prescaler. When it wraps from 31 to 0, `hi_q` increments. `lo_q[7:5]` keep their value.
- R8: Mode bits 01 select the 16-bit layout. `{hi_q, lo_q}` counts as a single 16-bit value.
- R9: A rollover from 0x1FFF (13-bit) or from 0xFFFF (16-bit) sets `ovf`. The flag stays set until an `ovf_clr` pulse clears it. If a rollover and `ovf_clr` fall in the same cycle, the flag ends up set.
- R10: The configuration byte holds the gate enable in bit 7, the source select in bit 6 and the mode in bits 5:4. `mode_q` returns these fields, and bits 3:0 always read as zero.
- R11: Mode bits 10 and 11 are reserved. Under either code the count holds its value even while counting is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run control; counting is allowed only while it is high |
| mode_we | input | 1 | Writes `wr_data` into the configuration byte |
| lo_we | input | 1 | Writes `wr_data` into the low count byte |
| hi_we | input | 1 | Writes `wr_data` into the high count byte |
| wr_data | input | 8 | Shared write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| ext_cnt | input | 1 | External event pin; falling edges are counted |
| ext_gate | input | 1 | External gate pin |
| mode_q | output | 8 | Configuration byte read-back |
| lo_q | output | 8 | Low count byte |
| hi_q | output | 8 | High count byte |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench goes after the carries at both layout boundaries: the 31-to-0 prescaler wrap, where a design that cascaded all eight bits would disturb `lo_q[7:5]`, and the rollovers at 0x1FFF and 0xFFFF, where a flag raised one count early or late would misreport the overflow. It also checks a rollover that coincides with `ovf_clr`, where a design that favoured the clear would lose the event. It drives one-cycle-high, one-cycle-low external pulses, which a detector without the previous-sample register would miss or double-count. It places a byte write in a cycle where counting is enabled, where a design that let the increment through would leave the low byte one past the loaded value. It also runs the gate case with the gate pin low, where a design that ignored the gate would keep counting.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

    localparam int BYTE_W     = 8;
    localparam int CNT_W      = 2 * BYTE_W;
    localparam int PRE_W      = 5;
    localparam int SYNC_DEPTH = 2;

    // configuration byte field positions
    localparam int GATE_BIT = 7;
    localparam int SRC_BIT  = 6;
    localparam int MODE_HI  = 5;
    localparam int MODE_LO  = 4;

    typedef enum logic [1:0] {
        MODE_13B  = 2'b00,
        MODE_16B  = 2'b01,
        MODE_RSV2 = 2'b10,
        MODE_RSV3 = 2'b11
    } cnt_mode_e;

    typedef struct packed {
        logic      gate_en;
        logic      ext_src;
        cnt_mode_e mode;
    } cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_t;

    typedef struct packed {
        cnt_t val;
        logic wrap;
    } step_t;

    function automatic cfg_t decode_cfg(logic [BYTE_W-1:0] b);
        cfg_t c;
        c.gate_en = b[GATE_BIT];
        c.ext_src = b[SRC_BIT];
        c.mode    = cnt_mode_e'(b[MODE_HI:MODE_LO]);
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] encode_cfg(cfg_t c);
        logic [BYTE_W-1:0] r;
        r                   = '0;
        r[GATE_BIT]         = c.gate_en;
        r[SRC_BIT]          = c.ext_src;
        r[MODE_HI:MODE_LO]  = c.mode;
        return r;
    endfunction

    // one count step in the chosen layout
    function automatic step_t bump(cnt_mode_e m, cnt_t c);
        step_t s;
        s.val  = c;
        s.wrap = 1'b0;
        case (m)
            MODE_13B: begin
                if (&c.lo[PRE_W-1:0]) begin
                    s.val.lo[PRE_W-1:0] = '0;
                    s.val.hi            = c.hi + BYTE_W'(1);
                    s.wrap              = &c.hi;
                end else begin
                    s.val.lo[PRE_W-1:0] = c.lo[PRE_W-1:0] + PRE_W'(1);
                end
            end
            MODE_16B: begin
                s.val  = cnt_t'(c + CNT_W'(1));
                s.wrap = &c;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
    parameter int W     = 2,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[DEPTH-1];

    AST_SYNC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stage[0] == $past(d)); // R6

endmodule

// File: rtl/gtc_tick.sv
module gtc_tick
    import gtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  cfg_t cfg,
    input  logic gate_s,
    input  logic pin_s,
    output logic tick
);

    logic pin_d;
    logic fall;
    logic allowed;

    always_ff @(posedge clk) begin
        if (rst) pin_d <= 1'b0;
        else     pin_d <= pin_s;
    end

    assign fall    = pin_d & ~pin_s;
    assign allowed = run_en & (~cfg.gate_en | gate_s);
    assign tick    = allowed & (cfg.ext_src ? fall : 1'b1);

    AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall); // R6

endmodule

// File: rtl/gtc_count.sv
module gtc_count
    import gtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  cnt_mode_e         mode,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ovf_clr,
    output cnt_t              cnt,
    output logic              ovf
);

    step_t nxt;
    logic  any_wr;
    logic  wrap_hit;

    assign nxt      = bump(mode, cnt);
    assign any_wr   = lo_we | hi_we;
    assign wrap_hit = tick & ~any_wr & nxt.wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (any_wr) begin
            if (lo_we) cnt.lo <= wr_data;
            if (hi_we) cnt.hi <= wr_data;
        end else if (tick) begin
            cnt <= nxt.val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           ovf <= 1'b0;
        else if (wrap_hit) ovf <= 1'b1;
        else if (ovf_clr)  ovf <= 1'b0;
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        lo_we |=> cnt.lo == $past(wr_data)); // R2

    AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (hi_we && !lo_we) |=> cnt.lo == $past(cnt.lo)); // R2

    AST_STEP_16: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == MODE_16B && !any_wr) |=> cnt == cnt_t'($past(cnt) + CNT_W'(1))); // R8

    AST_PRESCALE_TOP: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_13B && !lo_we) |=> cnt.lo[BYTE_W-1:PRE_W] == $past(cnt.lo[BYTE_W-1:PRE_W])); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf); // R9

    AST_RSV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && !any_wr) |=> $stable(cnt)); // R11

endmodule

// File: rtl/gtc_timer.sv
module gtc_timer
    import gtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic       mode_we,
    input  logic       lo_we,
    input  logic       hi_we,
    input  logic [7:0] wr_data,
    input  logic       ovf_clr,
    input  logic       ext_cnt,
    input  logic       ext_gate,
    output logic [7:0] mode_q,
    output logic [7:0] lo_q,
    output logic [7:0] hi_q,
    output logic       ovf
);

    cfg_t       cfg_r;
    logic [1:0] pins_s;
    logic       tick;
    cnt_t       cnt;

    always_ff @(posedge clk) begin
        if (rst)          cfg_r <= '0;
        else if (mode_we) cfg_r <= decode_cfg(wr_data);
    end

    gtc_sync #(.W(2), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ext_gate, ext_cnt}),
        .q   (pins_s)
    );

    gtc_tick u_tick (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .cfg    (cfg_r),
        .gate_s (pins_s[1]),
        .pin_s  (pins_s[0]),
        .tick   (tick)
    );

    gtc_count u_count (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (cfg_r.mode),
        .lo_we   (lo_we),
        .hi_we   (hi_we),
        .wr_data (wr_data),
        .ovf_clr (ovf_clr),
        .cnt     (cnt),
        .ovf     (ovf)
    );

    assign mode_q = encode_cfg(cfg_r);
    assign lo_q   = cnt.lo;
    assign hi_q   = cnt.hi;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !lo_we && !hi_we) |=> $stable({hi_q, lo_q})); // R4

    AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (cfg_r.gate_en && !pins_s[1] && !lo_we && !hi_we) |=> $stable({hi_q, lo_q})); // R5

    always_comb begin
        AST_CFG_LOW_ZERO: assert (mode_q[3:0] == 4'h0); // R10
    end

endmodule

// File: tb/gtc_timer_bench.sv
`timescale 1ns/100ps
module gtc_timer_bench;

    logic       clk = 1'b0;
    logic       rst, run_en, mode_we, lo_we, hi_we, ovf_clr, ext_cnt, ext_gate;
    logic [7:0] wr_data;
    logic [7:0] mode_q, lo_q, hi_q;
    logic       ovf;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    gtc_timer u_gtc_timer (
        .clk(clk), .rst(rst), .run_en(run_en), .mode_we(mode_we),
        .lo_we(lo_we), .hi_we(hi_we), .wr_data(wr_data), .ovf_clr(ovf_clr),
        .ext_cnt(ext_cnt), .ext_gate(ext_gate),
        .mode_q(mode_q), .lo_q(lo_q), .hi_q(hi_q), .ovf(ovf)
    );

    // {mode, lo init, hi init, cycles, exp lo, exp hi, exp ovf}
    localparam int NV = 9;
    localparam logic [56:0] VECS [NV] = '{
        {8'h10, 8'h00, 8'h00, 16'd5,  8'h05, 8'h00, 1'b0},  // R8 R3
        {8'h10, 8'hFE, 8'h00, 16'd3,  8'h01, 8'h01, 1'b0},  // R8 carry
        {8'h10, 8'hFD, 8'hFF, 16'd5,  8'h02, 8'h00, 1'b1},  // R9 16-bit wrap
        {8'h00, 8'h1E, 8'h00, 16'd3,  8'h01, 8'h01, 1'b0},  // R7 carry
        {8'h00, 8'hE0, 8'h00, 16'd33, 8'hE1, 8'h01, 1'b0},  // R7 upper bits kept
        {8'h00, 8'h1F, 8'hFF, 16'd2,  8'h01, 8'h00, 1'b1},  // R9 13-bit wrap
        {8'h00, 8'h1E, 8'hFF, 16'd1,  8'h1F, 8'hFF, 1'b0},  // R9 one short
        {8'h20, 8'h12, 8'h34, 16'd10, 8'h12, 8'h34, 1'b0},  // R11
        {8'h30, 8'h56, 8'h78, 16'd10, 8'h56, 8'h78, 1'b0}   // R11
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_wr(input int which, input logic [7:0] v);
        wr_data = v;
        case (which)
            0: mode_we = 1'b1;
            1: lo_we   = 1'b1;
            2: hi_we   = 1'b1;
            default: ovf_clr = 1'b1;
        endcase
        @(negedge clk);
        mode_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic run_for(input int n);
        run_en = 1'b1;
        repeat (n) @(negedge clk);
        run_en = 1'b0;
    endtask

    task automatic load(input logic [7:0] m, input logic [7:0] l, input logic [7:0] h);
        pulse_wr(0, m);
        pulse_wr(1, l);
        pulse_wr(2, h);
        pulse_wr(3, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; run_en = 1'b0; mode_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0;
        ovf_clr = 1'b0; ext_cnt = 1'b0; ext_gate = 1'b0; wr_data = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 count", {hi_q, lo_q}, 16'h0000);
        check("R1 mode", {8'h00, mode_q}, 16'h0000);
        check("R1 ovf", {15'd0, ovf}, 16'h0000);

        // R10 field layout, low nibble reads zero
        pulse_wr(0, 8'hFF);
        check("R10 readback", {8'h00, mode_q}, 16'h00F0);
        pulse_wr(0, 8'h10);
        check("R10 readback", {8'h00, mode_q}, 16'h0010);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [56:0] v;
            v = VECS[i];
            load(v[56:49], v[48:41], v[40:33]);
            run_for(int'(v[32:17]));
            @(negedge clk);
            check("R3/R7/R8/R11 lo", {8'h00, lo_q}, {8'h00, v[16:9]});
            check("R3/R7/R8/R11 hi", {8'h00, hi_q}, {8'h00, v[8:1]});
            check("R9 ovf", {15'd0, ovf}, {15'd0, v[0]});
        end

        // R4 hold while stopped
        load(8'h10, 8'h21, 8'h43);
        repeat (10) @(negedge clk);
        check("R4 hold", {hi_q, lo_q}, 16'h4321);

        // R2 write beats increment
        load(8'h10, 8'h10, 8'h00);
        run_en = 1'b1; hi_we = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        hi_we = 1'b0;
        check("R2 write blocks step", {hi_q, lo_q}, 16'h7710);
        @(negedge clk);
        run_en = 1'b0;
        check("R2 step resumes", {hi_q, lo_q}, 16'h7711);
        run_en = 1'b1; lo_we = 1'b1; wr_data = 8'h40;
        @(negedge clk);
        lo_we = 1'b0; run_en = 1'b0;
        check("R2 lo load", {hi_q, lo_q}, 16'h7740);

        // R9 set wins over clear, sticky, then cleared
        load(8'h10, 8'hFF, 8'hFF);
        run_en = 1'b1; ovf_clr = 1'b1;
        @(negedge clk);
        run_en = 1'b0; ovf_clr = 1'b0;
        check("R9 set beats clear", {15'd0, ovf}, 16'h0001);
        check("R9 wrap value", {hi_q, lo_q}, 16'h0000);
        repeat (5) @(negedge clk);
        check("R9 sticky", {15'd0, ovf}, 16'h0001);
        pulse_wr(3, 8'h00);
        check("R9 cleared", {15'd0, ovf}, 16'h0000);

        // R5 gate
        load(8'h90, 8'h00, 8'h00);
        run_for(10);
        check("R5 gate low blocks", {hi_q, lo_q}, 16'h0000);
        ext_gate = 1'b1;
        repeat (5) @(negedge clk);
        check("R5 gate high, run low", {hi_q, lo_q}, 16'h0000);
        run_for(6);
        check("R5 gate high counts", {hi_q, lo_q}, 16'h0006);
        ext_gate = 1'b0;
        repeat (3) @(negedge clk);
        run_for(5);
        check("R5 gate dropped", {hi_q, lo_q}, 16'h0006);

        // R6 external source
        load(8'h50, 8'h00, 8'h00);
        run_en = 1'b1;
        ext_cnt = 1'b1;
        repeat (10) @(negedge clk);
        check("R6 steady high no count", {hi_q, lo_q}, 16'h0000);
        ext_cnt = 1'b0;
        repeat (5) @(negedge clk);
        check("R6 first fall", {hi_q, lo_q}, 16'h0001);
        for (int k = 0; k < 7; k++) begin
            ext_cnt = 1'b1; repeat (2) @(negedge clk);
            ext_cnt = 1'b0; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check("R6 slow pulses", {hi_q, lo_q}, 16'h0008);
        for (int k = 0; k < 6; k++) begin
            ext_cnt = 1'b1; @(negedge clk);
            ext_cnt = 1'b0; @(negedge clk);
        end
        repeat (4) @(negedge clk);
        run_en = 1'b0;
        check("R6 fastest pulses", {hi_q, lo_q}, 16'h000E);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule